// File: doc/BRIEF.md
# Timer Counter Clear-Source Selector

This block is one channel of a general-purpose timer. It holds a free-running 16-bit up-counter and four general registers, A to D. Each general register works in one of two modes. In compare mode it raises an event when the counter reaches its value. In capture mode it latches the counter on a rising edge of its own input pin. A 3-bit clear-select code picks which event returns the counter to zero. The code can name one of the four registers, turn clearing off, or make the channel follow clears from its sibling channels.

Several channels are tied together through a synchronization bus. When a channel that has sync enabled clears itself from its own source, it sends a one-cycle pulse. A channel that selects synchronized clearing and has sync enabled clears when it sees that pulse. Registers C and D can be placed in buffer mode. In that mode they produce no events at all. A reduced build keeps only registers A and B, and its clear-select code is 2 bits wide.

Software reaches the channel through a small word-wide write/read port. Address 0 is the control word. Address 1 is the counter. Addresses 2 to 5 are registers A to D.

Top module: `tmr_clr_chan`

## Requirements
- R1: After reset the counter, all general registers, the control word and the clear pulse are zero.
- R2: The counter increments by one on each clock with count enable high and wraps from 0xFFFF to 0. It holds when count enable is low and no clear occurs.
- R3: Clear-select codes 000 and 100 (control bits [2:0]) never clear the counter, even when register events occur.
- R4: Code 001 clears the counter on the next clock after a register A event, and code 010 does the same for register B. A compare event is the counter equal to the register while count enable is high and the register's mode bit is 0.
- R5: Code 101 clears the counter on a register C event, and code 110 on a register D event.
- R6: With its mode bit set to 1 (control bits [7:4] for A..D), a register copies the counter on a rising edge of its capture pin. The copy lands on the third clock after the pin rises (two synchronizer stages and one edge stage). That capture counts as the register's event for clearing.
- R7: Codes 011 and 111 clear the counter on the clock after the sync input is high, but only while the sync enable (control bit 3) is 1. With the enable at 0 the sync input has no effect.
- R8: With buffer mode set for C (control bit 8) or for D (control bit 9), that register makes neither compare nor capture events. It never clears the counter and never captures.
- R9: The clear pulse output is high for the cycle after a clear from the channel's own A/B/C/D source while the sync enable is 1. A synchronized clear never raises it. A clear overridden by a counter write never raises it.
- R10: In the same cycle, a counter write has priority over a clear, and a clear has priority over an increment.
- R11: In the reduced build, control bit 2 reads 0 and ignores writes, so code 1x1 acts as x01. Registers C and D read 0 and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_en | input | 1 | Count enable |
| cap_in | input | NREG | Capture pins, one per general register |
| sync_clr_in | input | 1 | Clear notice from channels running in sync |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Write address (0 control, 1 counter, 2..5 A..D) |
| wr_data | input | CNT_W | Write data |
| rd_addr | input | 3 | Read address, same map |
| rd_data | output | CNT_W | Read data (combinational) |
| cnt_out | output | CNT_W | Current counter value |
| clr_pulse_out | output | 1 | One-cycle clear notice to sibling channels |

## Verification
The bench keeps a behavioural model and checks against it on every clock. It aims at the cases where a plausible design goes wrong:
- Decode mistakes: a design that decoded 100 as a live code, or swapped C and D, clears at the wrong count.
- Gating mistakes: one that ignored the sync enable or the buffer-mode gate clears when it should keep counting.
- Priority mistakes: a wrong priority order shows up as a counter that ignores a write.
- Pulse mistakes: a pulse raised on synchronized clears would echo around the bus.
- Capture timing: captures are checked with exact synchronizer latency, so a missing or extra stage gives a captured value off by one.

The reduced build is checked on its own: a stored reserved bit would read back as 1.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    // Control word layout (LSB first): clr_sel[2:0], sync_en, cap_mode[3:0], buf_c, buf_d
    typedef struct packed {
        logic       buf_d;
        logic       buf_c;
        logic [3:0] cap_mode;
        logic       sync_en;
        logic [2:0] clr_sel;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam logic [2:0] ADDR_CTRL = 3'd0;
    localparam logic [2:0] ADDR_CNT  = 3'd1;
    localparam logic [2:0] ADDR_GR0  = 3'd2;

    localparam logic [2:0] SEL_NONE0 = 3'b000;
    localparam logic [2:0] SEL_A     = 3'b001;
    localparam logic [2:0] SEL_B     = 3'b010;
    localparam logic [2:0] SEL_SYNC0 = 3'b011;
    localparam logic [2:0] SEL_NONE1 = 3'b100;
    localparam logic [2:0] SEL_C     = 3'b101;
    localparam logic [2:0] SEL_D     = 3'b110;
    localparam logic [2:0] SEL_SYNC1 = 3'b111;

endpackage

// File: rtl/tmr_edge_det.sv
module tmr_edge_det #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pin,
    output logic [W-1:0] rise
);

    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
        logic [W-1:0] s3;
    } sy_t;

    sy_t sy_d, sy_q;

    always_comb begin
        sy_d.s1 = pin;
        sy_d.s2 = sy_q.s1;
        sy_d.s3 = sy_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sy_q <= '0;
        else        sy_q <= sy_d;
    end

    assign rise = sy_q.s2 & ~sy_q.s3;

endmodule

// File: rtl/tmr_evt_gen.sv
module tmr_evt_gen #(
    parameter int CNT_W = 16,
    parameter int NREG  = 4
) (
    input  logic [CNT_W-1:0]           cnt,
    input  logic                       cnt_en,
    input  logic [NREG-1:0][CNT_W-1:0] gr,
    input  logic [NREG-1:0]            cap_mode,
    input  logic [NREG-1:0]            gate,
    input  logic [NREG-1:0]            rise,
    output logic [NREG-1:0]            evt,
    output logic [NREG-1:0]            cap_take
);

    for (genvar g = 0; g < NREG; g++) begin : g_reg
        logic hit_cmp;
        logic hit_cap;
        assign hit_cmp     = cnt_en && (cnt == gr[g]) && !cap_mode[g];
        assign hit_cap     = rise[g] && cap_mode[g];
        assign evt[g]      = (hit_cmp || hit_cap) && !gate[g];
        assign cap_take[g] = hit_cap && !gate[g];
    end

endmodule

// File: rtl/tmr_clr_sel.sv
module tmr_clr_sel
    import tmr_pkg::*;
(
    input  logic [2:0] sel,
    input  logic [3:0] evt,
    input  logic       sync_en,
    input  logic       sync_in,
    output logic       own_clr,
    output logic       sync_clr
);

    always_comb begin
        own_clr  = 1'b0;
        sync_clr = 1'b0;
        unique case (sel)
            SEL_A:     own_clr  = evt[0];
            SEL_B:     own_clr  = evt[1];
            SEL_C:     own_clr  = evt[2];
            SEL_D:     own_clr  = evt[3];
            SEL_SYNC0,
            SEL_SYNC1: sync_clr = sync_en && sync_in;
            SEL_NONE0,
            SEL_NONE1: ;
            default:   ;
        endcase
    end

endmodule

// File: rtl/tmr_clr_chan.sv
module tmr_clr_chan
    import tmr_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter bit FULL_CH = 1'b1,
    localparam int NREG   = FULL_CH ? 4 : 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnt_en,
    input  logic [NREG-1:0]  cap_in,
    input  logic             sync_clr_in,
    input  logic             wr_en,
    input  logic [2:0]       wr_addr,
    input  logic [CNT_W-1:0] wr_data,
    input  logic [2:0]       rd_addr,
    output logic [CNT_W-1:0] rd_data,
    output logic [CNT_W-1:0] cnt_out,
    output logic             clr_pulse_out
);

    localparam logic [CTRL_W-1:0] CTRL_MASK = FULL_CH ? {CTRL_W{1'b1}} : CTRL_W'(10'h03B);

    typedef struct packed {
        logic [CNT_W-1:0]           cnt;
        logic [NREG-1:0][CNT_W-1:0] gr;
        ctrl_t                      ctrl;
        logic                       pulse;
    } st_t;

    st_t st_d, st_q;

    logic [NREG-1:0] rise;
    logic [NREG-1:0] gate;
    logic [NREG-1:0] evt;
    logic [NREG-1:0] cap_take;
    logic [3:0]      evt4;
    logic            own_clr;
    logic            sync_clr;
    logic            wr_cnt;
    logic [2:0]      sel_q;
    logic            sync_en_q;

    assign sel_q     = st_q.ctrl.clr_sel;
    assign sync_en_q = st_q.ctrl.sync_en;
    assign wr_cnt    = wr_en && (wr_addr == ADDR_CNT);

    tmr_edge_det #(.W(NREG)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .pin  (cap_in),
        .rise (rise)
    );

    if (FULL_CH) begin : g_full
        assign gate = {st_q.ctrl.buf_d, st_q.ctrl.buf_c, 2'b00};
        assign evt4 = evt;
    end else begin : g_red
        assign gate = '0;
        assign evt4 = {2'b00, evt};
    end

    tmr_evt_gen #(.CNT_W(CNT_W), .NREG(NREG)) u_evt (
        .cnt     (st_q.cnt),
        .cnt_en  (cnt_en),
        .gr      (st_q.gr),
        .cap_mode(st_q.ctrl.cap_mode[NREG-1:0]),
        .gate    (gate),
        .rise    (rise),
        .evt     (evt),
        .cap_take(cap_take)
    );

    tmr_clr_sel u_sel (
        .sel     (sel_q),
        .evt     (evt4),
        .sync_en (sync_en_q),
        .sync_in (sync_clr_in),
        .own_clr (own_clr),
        .sync_clr(sync_clr)
    );

    always_comb begin
        st_d = st_q;

        // counter: write > clear > increment
        if (wr_cnt) begin
            st_d.cnt = wr_data;
        end else if (own_clr || sync_clr) begin
            st_d.cnt = '0;
        end else if (cnt_en) begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end

        st_d.pulse = own_clr && sync_en_q && !wr_cnt;

        for (int i = 0; i < NREG; i++) begin
            if (wr_en && (wr_addr == 3'(int'(ADDR_GR0) + i))) begin
                st_d.gr[i] = wr_data;
            end else if (cap_take[i]) begin
                st_d.gr[i] = st_q.cnt;
            end
        end

        if (wr_en && (wr_addr == ADDR_CTRL)) begin
            st_d.ctrl = ctrl_t'(wr_data[CTRL_W-1:0] & CTRL_MASK);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_CTRL) begin
            rd_data = CNT_W'(st_q.ctrl);
        end else if (rd_addr == ADDR_CNT) begin
            rd_data = st_q.cnt;
        end else begin
            for (int i = 0; i < NREG; i++) begin
                if (rd_addr == 3'(int'(ADDR_GR0) + i)) rd_data = st_q.gr[i];
            end
        end
    end

    assign cnt_out       = st_q.cnt;
    assign clr_pulse_out = st_q.pulse;

endmodule

// File: rtl/tmr_clr_chan_chk.sv
module tmr_clr_chan_chk #(
    parameter int CNT_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cnt_en,
    input logic             wr_cnt,
    input logic [CNT_W-1:0] wr_data,
    input logic [CNT_W-1:0] cnt,
    input logic             pulse,
    input logic [2:0]       sel,
    input logic             sync_en,
    input logic             sync_in,
    input logic [3:0]       evt
);

    // R3
    no_clear_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && cnt_en && (sel == 3'b000 || sel == 3'b100)) |=> cnt == $past(cnt) + CNT_W'(1));

    // R4
    clear_ab_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && ((sel == 3'b001 && evt[0]) || (sel == 3'b010 && evt[1]))) |=> cnt == '0);

    // R5
    clear_cd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && ((sel == 3'b101 && evt[2]) || (sel == 3'b110 && evt[3]))) |=> cnt == '0);

    // R7
    sync_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && cnt_en && !sync_en && sel[1:0] == 2'b11) |=> cnt == $past(cnt) + CNT_W'(1));

    // R2
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_cnt && !cnt_en && evt == 4'b0000 && !(sync_en && sync_in && sel[1:0] == 2'b11)) |=> $stable(cnt));

    // R9
    pulse_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pulse |-> (cnt == '0 && $past(sync_en)));

    // R10
    write_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt == $past(wr_data));

endmodule

bind tmr_clr_chan tmr_clr_chan_chk #(.CNT_W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_en (cnt_en),
    .wr_cnt (wr_cnt),
    .wr_data(wr_data),
    .cnt    (cnt_out),
    .pulse  (clr_pulse_out),
    .sel    (sel_q),
    .sync_en(sync_en_q),
    .sync_in(sync_clr_in),
    .evt    (evt4)
);

// File: tb/test_tmr_clr_chan.sv
module test_tmr_clr_chan;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cnt_en = 1'b0;
    logic [3:0]  cap_in = '0;
    logic        sync_in = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [15:0] wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [15:0] rd_data;
    logic [15:0] cnt_out;
    logic        pulse;

    logic        r_cnt_en = 1'b0;
    logic        r_wr_en = 1'b0;
    logic [2:0]  r_wr_addr = '0;
    logic [15:0] r_wr_data = '0;
    logic [2:0]  r_rd_addr = '0;
    logic [15:0] r_rd_data;
    logic [15:0] r_cnt;
    logic        r_pulse;

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit started = 0;
    string tag = "R1";
    int rd_sel = 0;

    always #5 clk = ~clk;

    tmr_clr_chan #(.CNT_W(16), .FULL_CH(1'b1)) i_tmr_clr_chan (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_in(cap_in),
        .sync_clr_in(sync_in), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .cnt_out(cnt_out), .clr_pulse_out(pulse)
    );

    tmr_clr_chan #(.CNT_W(16), .FULL_CH(1'b0)) i_tmr_clr_chan_red (
        .clk(clk), .rst_n(rst_n), .cnt_en(r_cnt_en), .cap_in(2'b00),
        .sync_clr_in(1'b0), .wr_en(r_wr_en), .wr_addr(r_wr_addr), .wr_data(r_wr_data),
        .rd_addr(r_rd_addr), .rd_data(r_rd_data), .cnt_out(r_cnt), .clr_pulse_out(r_pulse)
    );

    // behavioural reference of the full channel
    logic [15:0] m_cnt;
    logic [15:0] m_gr [4];
    logic [9:0]  m_ctl;
    logic        m_pulse;
    logic [3:0]  p1, p2, p3;

    function automatic logic [15:0] m_read(int a);
        if (a == 0) return {6'b0, m_ctl};
        if (a == 1) return m_cnt;
        return m_gr[a-2];
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_cnt = 0; m_ctl = 0; m_pulse = 0; p1 = 0; p2 = 0; p3 = 0;
            for (int i = 0; i < 4; i++) m_gr[i] = 0;
        end else begin
            bit ev [4];
            bit tk [4];
            bit own, syn, wc;
            logic [15:0] nc;
            int s;
            for (int i = 0; i < 4; i++) begin
                bit cm, cp, gt;
                cm = cnt_en && (m_cnt == m_gr[i]) && !m_ctl[4+i];
                cp = p2[i] && !p3[i] && m_ctl[4+i];
                gt = (i == 2 && m_ctl[8]) || (i == 3 && m_ctl[9]);
                ev[i] = (cm || cp) && !gt;
                tk[i] = cp && !gt;
            end
            s = int'(m_ctl[2:0]);
            own = (s == 1 && ev[0]) || (s == 2 && ev[1]) || (s == 5 && ev[2]) || (s == 6 && ev[3]);
            syn = (s == 3 || s == 7) && m_ctl[3] && sync_in;
            wc = wr_en && wr_addr == 3'd1;
            if (wc) nc = wr_data;
            else if (own || syn) nc = 0;
            else if (cnt_en) nc = m_cnt + 16'd1;
            else nc = m_cnt;
            m_pulse = own && m_ctl[3] && !wc;
            for (int i = 0; i < 4; i++) begin
                if (wr_en && int'(wr_addr) == 2 + i) m_gr[i] = wr_data;
                else if (tk[i]) m_gr[i] = m_cnt;
            end
            if (wr_en && wr_addr == 3'd0) m_ctl = wr_data[9:0];
            m_cnt = nc;
            p3 = p2; p2 = p1; p1 = cap_in;
        end
    end

    task automatic check(string req, string what, logic [15:0] act, logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // per-clock comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && started) begin
            check(tag, "counter", cnt_out, m_cnt);
            check(tag, "pulse", {15'b0, pulse}, {15'b0, m_pulse});
            rd_addr = 3'(rd_sel);
            #1;
            check(tag, "readback", rd_data, m_read(rd_sel));
            rd_sel = (rd_sel + 1) % 6;
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            $display("FAIL R1 watchdog actual=%0d expected<150000", cyc);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [2:0] a, logic [15:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rwr(logic [2:0] a, logic [15:0] d);
        r_wr_en = 1'b1; r_wr_addr = a; r_wr_data = d;
        @(negedge clk);
        r_wr_en = 1'b0;
    endtask

    task automatic cap_pulse(int i);
        cap_in[i] = 1'b1;
        idle(1);
        cap_in[i] = 1'b0;
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R1 reset state
        check("R1", "reset counter", cnt_out, 16'h0);
        check("R1", "reset pulse", {15'b0, pulse}, 16'h0);
        rd_addr = 3'd0; #1;
        check("R1", "reset control", rd_data, 16'h0);
        started = 1;
        idle(1);

        // R2 counting, hold and wrap
        tag = "R2";
        cnt_en = 1'b1; idle(10);
        cnt_en = 1'b0; idle(4);
        wr(3'd1, 16'hFFFC);
        cnt_en = 1'b1; idle(8);

        // R3 codes 000 and 100 with live events
        tag = "R3";
        wr(3'd2, 16'd5); wr(3'd4, 16'd6);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0000); idle(12);
        wr(3'd1, 16'd0);
        wr(3'd0, 16'h0004); idle(12);

        // R4 clear on A and on B
        tag = "R4";
        wr(3'd1, 16'd0); wr(3'd2, 16'd7);
        wr(3'd0, 16'h0001); idle(25);
        wr(3'd3, 16'd4);
        wr(3'd0, 16'h0002); idle(15);

        // R5 clear on C and on D
        tag = "R5";
        wr(3'd4, 16'd6);
        wr(3'd0, 16'h0005); idle(20);
        wr(3'd5, 16'd9);
        wr(3'd0, 16'h0006); idle(25);

        // R6 capture on A with clear, capture on B without
        tag = "R6";
        wr(3'd0, 16'h0011); idle(5);
        cap_pulse(0); idle(6);
        cap_pulse(0); idle(3);
        wr(3'd0, 16'h0020); idle(4);
        cap_pulse(1); idle(6);

        // R7 synchronized clear, enabled and disabled
        tag = "R7";
        wr(3'd0, 16'h000B); idle(3);
        sync_in = 1'b1; idle(1); sync_in = 1'b0; idle(4);
        wr(3'd0, 16'h000F); idle(2);
        sync_in = 1'b1; idle(2); sync_in = 1'b0; idle(3);
        wr(3'd0, 16'h0003); idle(2);
        sync_in = 1'b1; idle(4); sync_in = 1'b0; idle(2);

        // R8 buffer mode on C and D
        tag = "R8";
        wr(3'd1, 16'd0); wr(3'd4, 16'd3);
        wr(3'd0, 16'h0105); idle(15);
        wr(3'd5, 16'd4);
        wr(3'd0, 16'h0206); idle(15);
        wr(3'd0, 16'h0145); idle(2);
        cap_pulse(2); idle(6);

        // R9 clear pulse from own source, none from sync
        tag = "R9";
        wr(3'd1, 16'd0); wr(3'd2, 16'd5);
        wr(3'd0, 16'h0009); idle(20);
        wr(3'd0, 16'h000B);
        sync_in = 1'b1; idle(1); sync_in = 1'b0; idle(4);
        wr(3'd2, 16'd2);
        wr(3'd0, 16'h0001); idle(8);

        // R10 write beats clear beats increment
        tag = "R10";
        wr(3'd2, 16'd10);
        wr(3'd0, 16'h0009);
        wr(3'd1, 16'd10); wr(3'd1, 16'd10); wr(3'd1, 16'd10);
        idle(3);
        cnt_en = 1'b0;
        wr(3'd1, 16'd10); idle(2);
        cnt_en = 1'b1; idle(3);
        started = 0;
        cnt_en = 1'b0;
        wr(3'd0, 16'h0000);

        // R11 reduced channel
        tag = "R11";
        rwr(3'd0, 16'h0007);
        r_rd_addr = 3'd0; #1;
        check("R11", "reserved bit read", r_rd_data, 16'h0003);
        rwr(3'd0, 16'h0005);
        rwr(3'd2, 16'd3);
        rwr(3'd1, 16'd0);
        r_cnt_en = 1'b1;
        begin
            bit saw3, wrapped, over;
            saw3 = 0; wrapped = 0; over = 0;
            for (int k = 0; k < 12; k++) begin
                @(negedge clk);
                if (r_cnt > 16'd3) over = 1;
                if (saw3 && r_cnt == 16'd0) wrapped = 1;
                if (r_cnt == 16'd3) saw3 = 1;
            end
            check("R11", "code 101 acts as 001 bound", {15'b0, over}, 16'h0);
            check("R11", "code 101 acts as 001 clear", {15'b0, wrapped}, 16'h1);
        end
        r_cnt_en = 1'b0;
        rwr(3'd4, 16'h0055);
        r_rd_addr = 3'd4; #1;
        check("R11", "absent register C", r_rd_data, 16'h0000);
        r_rd_addr = 3'd5; #1;
        check("R11", "absent register D", r_rd_data, 16'h0000);

        idle(2);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule